// File: doc/BRIEF.md
# Byte-granular SPI data FIFO

This block sits between a register bus and a serial shift engine and holds one transmit queue and one receive queue. Both queues store 8-bit entries. A bus access can move 8, 16 or 32 bits, so it pushes or pops one, two or four bytes. The serial engine moves whole frames, and a frame takes one, two or four bytes depending on the configured frame length.

Byte counts are tracked exactly, but the status that software and DMA see works in packets. A packet is a programmed number of frames. The transmit side reports whether a whole packet still fits. The receive side reports three things: whether a whole packet is stored, whether at least a 32-bit word is waiting, and how many frames remain below one packet. That last value lets a short tail be drained once a transfer has ended. Dropping the peripheral enable empties the receive queue. Separate enable bits gate two DMA request lines, and each line follows its own packet flag.

Top module: `spi_byte_fifo`

## Requirements
- R1: After reset both queues are empty. `tx_pkt_space` is 1 (when a packet fits in DEPTH bytes), and `rx_pkt_ready`, `rx_word_ne`, `rx_res_lvl` and `eng_tx_valid` are 0.
- R2: A bus write pushes 1, 2 or 4 bytes for `bus_wsize` code 0, 1 or 2/3, lowest byte lane first. A write is dropped entirely when fewer free bytes remain than it carries.
- R3: Frame size in bytes is 1 for `frame_len_m1` 0..7, 2 for 8..15 and 4 for 16..31. `eng_tx_valid` is 1 while at least one frame's bytes are queued. `eng_tx_frame` assembles them with the oldest byte in bits 7:0, and `eng_tx_pop` removes them.
- R4: Packet bytes equal (`pkt_frames_m1`+1) times the frame bytes. `tx_pkt_space` is 1 exactly while the free transmit bytes are at least one packet, so repeated byte writes fill the queue until it drops.
- R5: `eng_rx_ready` is 1 while enabled and at least one frame of free space remains. `eng_rx_push` then stores the low frame-size bytes of `eng_rx_frame`, oldest byte being bits 7:0.
- R6: A bus read pops min(access bytes, stored bytes) and returns them in the low lanes with the upper lanes zero. A read of an empty receive queue returns zero and changes nothing.
- R7: `rx_pkt_ready` is 1 exactly while at least one packet of bytes is stored.
- R8: `rx_word_ne` is 1 while at least 4 bytes are stored. `rx_res_lvl` is 0 when a full packet is stored; otherwise it is the number of whole stored frames, saturated at 3.
- R9: With `enable` low the receive queue is empty one edge later, engine pushes are refused, and the transmit queue keeps its contents.
- R10: `tx_dma_req` equals `tx_dma_en` AND `tx_pkt_space`, and `rx_dma_req` equals `rx_dma_en` AND `rx_pkt_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low empties the receive queue |
| frame_len_m1 | input | 5 | Frame length in bits minus one |
| pkt_frames_m1 | input | 4 | Frames per packet minus one |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| bus_wr | input | 1 | Bus write strobe |
| bus_wsize | input | 2 | Write size code: 0 byte, 1 half, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_rsize | input | 2 | Read size code: 0 byte, 1 half, 2/3 word |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| tx_pkt_space | output | 1 | Room for one more packet in the transmit queue |
| rx_pkt_ready | output | 1 | At least one packet stored in the receive queue |
| rx_word_ne | output | 1 | At least 32 bits stored in the receive queue |
| rx_res_lvl | output | 2 | Whole frames stored below one packet |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| eng_tx_pop | input | 1 | Engine takes one transmit frame |
| eng_tx_valid | output | 1 | A whole transmit frame is queued |
| eng_tx_frame | output | 32 | Oldest transmit frame |
| eng_rx_push | input | 1 | Engine delivers one receive frame |
| eng_rx_ready | output | 1 | Receive queue can take one frame |
| eng_rx_frame | input | 32 | Frame delivered by the engine |

## Verification
Read data and the oldest transmit frame are combinational: they are valid in the same cycle as `bus_rd`, or while `eng_tx_valid` is high, before the edge that pops them. The transmit flags, the receive flags, the residual level and the DMA requests come from registered byte counts, so they change one edge after the access that moved data, and the flush also completes on that edge. The bench therefore drives strobes just after a falling edge and checks combinational results 1 ns later. It removes the strobes after the rising edge and checks every flag at the following falling edge. A byte-queue scoreboard per direction supplies the expected values.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;

  // bytes occupied by one frame of (len_m1 + 1) bits
  function automatic logic [2:0] frame_bytes(input logic [4:0] len_m1);
    if (len_m1 < 5'd8)       return 3'd1;
    else if (len_m1 < 5'd16) return 3'd2;
    else                     return 3'd4;
  endfunction

  // bytes moved by one bus access of the given size code
  function automatic logic [2:0] access_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bytes in one packet: (frames_m1 + 1) * frame bytes, at most 64
  function automatic logic [6:0] packet_bytes(input logic [3:0] frames_m1,
                                              input logic [2:0] fb);
    return ({3'd0, frames_m1} + 7'd1) * {4'd0, fb};
  endfunction

  // zero every byte lane at or above n
  function automatic logic [31:0] keep_bytes(input logic [31:0] d,
                                             input logic [2:0] n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 4; i++)
      if (i < int'(n)) m[8*i +: 8] = 8'hFF;
    return d & m;
  endfunction

  // whole frames stored below one packet, saturated at 3
  function automatic logic [1:0] residual_frames(input logic [6:0] cnt,
                                                 input logic [6:0] pkt,
                                                 input logic [2:0] fb);
    logic [6:0] frames;
    if (cnt >= pkt) return 2'd0;
    case (fb)
      3'd1:    frames = cnt;
      3'd2:    frames = cnt >> 1;
      default: frames = cnt >> 2;
    endcase
    return (frames > 7'd3) ? 2'd3 : frames[1:0];
  endfunction

endpackage

// File: rtl/spf_byte_ring.sv
`timescale 1ns/1ps
module spf_byte_ring #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic [2:0]    pop_n,
  output logic [CW-1:0] count,
  output logic [CW-1:0] free,
  output logic [31:0]   peek
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  assign count = cnt_q;
  assign free  = CW'(DEPTH) - cnt_q;

  // four bytes from the head, zero past the stored data
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx = rd_ptr + AW'(g);
    assign peek[8*g +: 8] = (CW'(g) < cnt_q) ? mem[idx] : 8'h00;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> ({2'b0, push_n} <= {3'b0, free}));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> ({2'b0, pop_n} <= {3'b0, cnt_q}));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/spf_level_flags.sv
`timescale 1ns/1ps
module spf_level_flags #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] tx_cnt,
  input  logic [6:0] rx_cnt,
  input  logic [2:0] fb,
  input  logic [6:0] pkt,
  output logic       tx_space,
  output logic       rx_avail,
  output logic       rx_wne,
  output logic [1:0] rx_lvl
);
  import spf_pkg::*;

  logic [6:0] tx_free_w;

  assign tx_free_w = 7'(DEPTH) - tx_cnt;
  assign tx_space  = (tx_free_w >= pkt);
  assign rx_avail  = (rx_cnt >= pkt);
  assign rx_wne    = (rx_cnt >= 7'd4);
  assign rx_lvl    = residual_frames(rx_cnt, pkt, fb);

  // a non-zero residual means a partial packet of at least one frame
  a_r8_residual_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl != 2'd0) |-> (!rx_avail && (rx_cnt >= {4'd0, fb})));

  // a word waiting with a packet of 4 bytes or less means a packet is ready
  a_r7_word_implies_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wne && (pkt <= 7'd4)) |-> rx_avail);

endmodule

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [4:0]  frame_len_m1,
  input  logic [3:0]  pkt_frames_m1,
  input  logic        tx_dma_en,
  input  logic        rx_dma_en,
  input  logic        bus_wr,
  input  logic [1:0]  bus_wsize,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  input  logic [1:0]  bus_rsize,
  output logic [31:0] bus_rdata,
  output logic        tx_pkt_space,
  output logic        rx_pkt_ready,
  output logic        rx_word_ne,
  output logic [1:0]  rx_res_lvl,
  output logic        tx_dma_req,
  output logic        rx_dma_req,
  input  logic        eng_tx_pop,
  output logic        eng_tx_valid,
  output logic [31:0] eng_tx_frame,
  input  logic        eng_rx_push,
  output logic        eng_rx_ready,
  input  logic [31:0] eng_rx_frame
);
  import spf_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic [2:0]    fb;
  logic [2:0]    wr_n;
  logic [2:0]    rd_n;
  logic [2:0]    rd_take;
  logic [6:0]    pkt;
  logic [CW-1:0] tx_count, tx_free, rx_count, rx_free;
  logic [6:0]    tx_cnt7, tx_free7, rx_cnt7, rx_free7;
  logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [31:0]   tx_peek, rx_peek;
  logic          wr_accept, wr_drop, eng_pop_fire, eng_push_fire;
  logic          tx_space_w, rx_avail_w;

  // configuration arithmetic
  assign fb   = frame_bytes(frame_len_m1);
  assign pkt  = packet_bytes(pkt_frames_m1, fb);
  assign wr_n = access_bytes(bus_wsize);
  assign rd_n = access_bytes(bus_rsize);

  assign tx_cnt7  = 7'(tx_count);
  assign tx_free7 = 7'(tx_free);
  assign rx_cnt7  = 7'(rx_count);
  assign rx_free7 = 7'(rx_free);

  // transmit side: bus pushes, engine pops frames
  assign wr_accept    = bus_wr && ({4'd0, wr_n} <= tx_free7);
  assign wr_drop      = bus_wr && !wr_accept;
  assign tx_push_n    = wr_accept ? wr_n : 3'd0;
  assign eng_tx_valid = (tx_cnt7 >= {4'd0, fb});
  assign eng_pop_fire = eng_tx_pop && eng_tx_valid;
  assign tx_pop_n     = eng_pop_fire ? fb : 3'd0;
  assign eng_tx_frame = keep_bytes(tx_peek, fb);

  spf_byte_ring #(.DEPTH(DEPTH)) u_tx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (1'b0),
    .push_n    (tx_push_n),
    .push_data (bus_wdata),
    .pop_n     (tx_pop_n),
    .count     (tx_count),
    .free      (tx_free),
    .peek      (tx_peek)
  );

  // receive side: engine pushes frames, bus pops bytes
  assign eng_rx_ready  = enable && (rx_free7 >= {4'd0, fb});
  assign eng_push_fire = eng_rx_push && eng_rx_ready;
  assign rx_push_n     = eng_push_fire ? fb : 3'd0;
  assign rd_take       = (rx_cnt7 >= {4'd0, rd_n}) ? rd_n : rx_cnt7[2:0];
  assign rx_pop_n      = bus_rd ? rd_take : 3'd0;
  assign bus_rdata     = bus_rd ? keep_bytes(rx_peek, rd_take) : 32'h0;

  spf_byte_ring #(.DEPTH(DEPTH)) u_rx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!enable),
    .push_n    (rx_push_n),
    .push_data (keep_bytes(eng_rx_frame, fb)),
    .pop_n     (rx_pop_n),
    .count     (rx_count),
    .free      (rx_free),
    .peek      (rx_peek)
  );

  spf_level_flags #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_cnt   (tx_cnt7),
    .rx_cnt   (rx_cnt7),
    .fb       (fb),
    .pkt      (pkt),
    .tx_space (tx_space_w),
    .rx_avail (rx_avail_w),
    .rx_wne   (rx_word_ne),
    .rx_lvl   (rx_res_lvl)
  );

  assign tx_pkt_space = tx_space_w;
  assign rx_pkt_ready = rx_avail_w;
  assign tx_dma_req   = tx_dma_en && tx_space_w;
  assign rx_dma_req   = rx_dma_en && rx_avail_w;

  a_r2_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !eng_pop_fire) |=> (tx_count == $past(tx_count)));

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (rx_count == '0)) |-> (bus_rdata == 32'h0));

  a_r6_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (rx_count == '0) && !eng_push_fire) |=> (rx_count == '0));

  a_r9_disabled_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !eng_rx_ready);

  a_r3_pop_removes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_pop_fire && !wr_accept) |=> (tx_cnt7 == $past(tx_cnt7) - {4'd0, $past(fb)}));

endmodule

// File: tb/spi_byte_fifo_bench.sv
`timescale 1ns/1ps
module spi_byte_fifo_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [4:0]  frame_len_m1 = 5'd7;
  logic [3:0]  pkt_frames_m1 = 4'd3;
  logic        tx_dma_en = 1'b0, rx_dma_en = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_wsize = 2'd0, bus_rsize = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_pkt_space, rx_pkt_ready, rx_word_ne, tx_dma_req, rx_dma_req;
  logic [1:0]  rx_res_lvl;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic        eng_tx_valid, eng_rx_ready;
  logic [31:0] eng_tx_frame, eng_rx_frame = '0;

  always #10 clk = ~clk;

  spi_byte_fifo #(.DEPTH(DEPTH)) u_spi_byte_fifo (.*);

  // scoreboard queues of bytes, oldest first
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int checks = 0;
  int errors = 0;
  int fb_m = 1;
  int pb_m = 4;
  bit done = 1'b0;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int len_m1, input int thr);
    @(negedge clk);
    frame_len_m1  = 5'(len_m1);
    pkt_frames_m1 = 4'(thr);
    fb_m = (len_m1 < 8) ? 1 : ((len_m1 < 16) ? 2 : 4);
    pb_m = (thr + 1) * fb_m;
  endtask

  function automatic int exp_lvl();
    int left, f;
    if (rxq.size() >= pb_m) return 0;
    left = rxq.size();
    f = 0;
    while (left >= fb_m && f < 3) begin
      left -= fb_m;
      f++;
    end
    return f;
  endfunction

  task automatic check_flags(input string req);
    bit sp, av;
    @(negedge clk);
    #1;
    sp = (DEPTH - txq.size()) >= pb_m;
    av = rxq.size() >= pb_m;
    check_eq({req, " tx_pkt_space"}, 32'(tx_pkt_space), 32'(sp));
    check_eq({req, " rx_pkt_ready"}, 32'(rx_pkt_ready), 32'(av));
    check_eq({req, " rx_word_ne"}, 32'(rx_word_ne), 32'(rxq.size() >= 4));
    check_eq({req, " rx_res_lvl"}, 32'(rx_res_lvl), 32'(exp_lvl()));
    check_eq({req, " tx_dma_req"}, 32'(tx_dma_req), 32'(tx_dma_en && sp));
    check_eq({req, " rx_dma_req"}, 32'(rx_dma_req), 32'(rx_dma_en && av));
  endtask

  task automatic bus_write(input int sz, input logic [31:0] d);
    int n;
    bit acc;
    n = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
    @(negedge clk);
    acc = (DEPTH - txq.size()) >= n;
    bus_wr = 1'b1;
    bus_wsize = 2'(sz);
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    if (acc)
      for (int k = 0; k < n; k++) txq.push_back(d[8*k +: 8]);
  endtask

  task automatic eng_pop(input string req);
    bit v;
    logic [31:0] e;
    @(negedge clk);
    #1;
    v = txq.size() >= fb_m;
    check_eq({req, " eng_tx_valid"}, 32'(eng_tx_valid), 32'(v));
    if (v) begin
      e = '0;
      for (int k = 0; k < fb_m; k++) e[8*k +: 8] = txq[k];
      check_eq({req, " eng_tx_frame"}, eng_tx_frame, e);
    end
    eng_tx_pop = 1'b1;
    @(posedge clk);
    #1;
    eng_tx_pop = 1'b0;
    if (v)
      for (int k = 0; k < fb_m; k++) void'(txq.pop_front());
  endtask

  task automatic eng_push(input string req, input logic [31:0] f);
    bit r;
    @(negedge clk);
    #1;
    r = enable && ((DEPTH - rxq.size()) >= fb_m);
    check_eq({req, " eng_rx_ready"}, 32'(eng_rx_ready), 32'(r));
    eng_rx_push = 1'b1;
    eng_rx_frame = f;
    @(posedge clk);
    #1;
    eng_rx_push = 1'b0;
    if (r)
      for (int k = 0; k < fb_m; k++) rxq.push_back(f[8*k +: 8]);
  endtask

  task automatic bus_read(input string req, input int sz);
    int n;
    logic [31:0] e;
    n = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
    if (n > rxq.size()) n = rxq.size();
    @(negedge clk);
    bus_rd = 1'b1;
    bus_rsize = 2'(sz);
    #1;
    e = '0;
    for (int k = 0; k < n; k++) e[8*k +: 8] = rxq[k];
    check_eq({req, " bus_rdata"}, bus_rdata, e);
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
    for (int k = 0; k < n; k++) void'(rxq.pop_front());
  endtask

  task automatic set_enable(input bit v);
    @(negedge clk);
    enable = v;
    @(posedge clk);
    #1;
    if (!v) rxq.delete();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nw;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state with 1-byte frames, 4-frame packets
    check_flags("R1");
    eng_pop("R1");
    check_flags("R1 after empty pop");

    // R4, R2: byte writes fill until the packet-space flag drops
    nw = 0;
    while (nw < 32) begin
      @(negedge clk);
      #1;
      if (!tx_pkt_space) break;
      bus_write(0, 32'(nw + 8'h10));
      nw++;
    end
    check_eq("R4 byte writes before space drops", 32'(nw), 32'd13);
    check_flags("R4 full");
    bus_write(2, 32'hDEADBEEF);        // dropped, 3 free
    bus_write(1, 32'h0000BEEF);        // accepted
    bus_write(0, 32'h00000077);        // accepted, queue full
    bus_write(0, 32'h00000088);        // dropped
    check_flags("R2 after drops");
    for (int i = 0; i < 17; i++) eng_pop("R2 R3 byte frames");
    check_flags("R4 drained");

    // R3: 2-byte and 4-byte frames
    set_cfg(15, 0);
    bus_write(2, 32'hAABBCCDD);
    eng_pop("R3 half frame");
    eng_pop("R3 half frame");
    set_cfg(23, 0);
    bus_write(1, 32'h00003322);
    eng_pop("R3 partial word frame");
    bus_write(1, 32'h00005544);
    eng_pop("R3 word frame");

    // R10: DMA gating
    set_cfg(7, 3);
    @(negedge clk);
    tx_dma_en = 1'b1;
    rx_dma_en = 1'b1;
    check_flags("R10 enabled");

    // R5, R7, R8, R6: receive path with 2-byte frames, 2-frame packets
    set_cfg(15, 1);
    eng_push("R5", 32'hFFFF1234);
    check_flags("R8 one frame");
    eng_push("R5", 32'h00005678);
    check_flags("R7 packet ready");
    eng_push("R5", 32'h00009ABC);
    bus_read("R6 word", 2);
    check_flags("R8 tail");
    bus_read("R6 partial word", 2);
    check_flags("R6 empty");
    bus_read("R6 empty read", 2);
    check_flags("R6 empty unchanged");

    // R5, R8: 4-byte frames fill the queue, residual levels
    set_cfg(31, 3);
    for (int i = 0; i < 5; i++) begin
      eng_push("R5 fill", 32'h01020304 + 32'(i));
      check_flags("R8 word frames");
    end
    bus_read("R6 byte", 0);
    bus_read("R6 half", 1);
    check_flags("R8 after byte reads");

    // R8: residual saturates at 3
    set_enable(1'b0);
    set_enable(1'b1);
    set_cfg(7, 7);
    for (int i = 0; i < 5; i++) eng_push("R5 bytes", 32'(8'hA0 + i));
    check_flags("R8 saturated level");

    // R9: disable flushes receive side only
    bus_write(1, 32'h0000C3C2);
    set_enable(1'b0);
    check_flags("R9 flushed");
    eng_push("R9 refused", 32'h00000055);
    bus_read("R9 read after flush", 2);
    check_flags("R9 still empty");
    eng_pop("R9 tx kept");
    eng_pop("R9 tx kept");
    set_enable(1'b1);
    @(negedge clk);
    tx_dma_en = 1'b0;
    check_flags("R10 tx dma off");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule